// File: doc/BRIEF.md
# Interrupt Priority Resolver with Handler Address

This block looks at a set of interrupt ports. Each port has a pending bit and three programmed fields: a priority level, a register-set number and a non-maskable flag. The block picks the one port that should be serviced next. It then works out where that port's handler lives, using a programmable vector base and a programmable spacing between vectors. The chosen handler address goes out on a valid/ready stream, together with the winner's level, register-set number and non-maskable flag. A processor or a cascaded controller can consume this stream directly.

Arbitration and address arithmetic sit in front of a single output register. The register reloads whenever the consumer can take a new item. It freezes while an offered item waits to be accepted. The spacing is given as a 3-bit code `c`, which selects `4 << c` bytes per vector, so the multiply becomes a shift. The width of the level field is a build-time parameter.

Top module: `vec_prio_resolver`

## Requirements
- R1: While `rstN` is low, `outValid` is 0 and `outAddr`, `outLevel`, `outRegSet` and `outNmi` are all 0.
- R2: Among ports that are pending and have a nonzero level, the port with the numerically largest level wins.
- R3: When several candidate ports share the largest level, the lowest port index wins.
- R4: A port whose level is 0 never wins, even when its pending bit is set.
- R5: A port whose pending bit is clear never wins, whatever its level.
- R6: `outAddr` equals the winning index times the bytes-per-vector value, plus the aligned base. Bytes per vector is `4 << spacingCode`, where `spacingCode` is 0..7, giving 4 to 512 bytes.
- R7: Bits of `vecBase` below the spacing, that is bits `[spacingCode+1:0]`, are treated as zero in the address.
- R8: `outLevel`, `outRegSet` and `outNmi` carry the winning port's own level, register-set number and non-maskable flag.
- R9: `outValid` is 1 exactly when, at the last loading edge, at least one port was pending with a nonzero level.
- R10: While `outValid` is 1 and `outReady` is 0, `outValid` and the whole payload stay unchanged at the next edge.
- R11: When the output is not stalled, a change on the inputs shows on the outputs after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pendingVec | input | NUM_PORTS | Pending bit per port |
| portLevel | input | NUM_PORTS*LVL_W | Priority level per port, port i at bits [i*LVL_W +: LVL_W] |
| portRegSet | input | NUM_PORTS*RSET_W | Register-set number per port, packed the same way |
| portNmi | input | NUM_PORTS | Non-maskable flag per port |
| vecBase | input | ADDR_W | Vector table base address |
| spacingCode | input | SPACE_W | Bytes per vector = 4 << spacingCode |
| outValid | output | 1 | Stream item is offered |
| outReady | input | 1 | Consumer accepts the item |
| outAddr | output | ADDR_W | Handler address of the winner |
| outLevel | output | LVL_W | Level of the winner |
| outRegSet | output | RSET_W | Register-set number of the winner |
| outNmi | output | 1 | Non-maskable flag of the winner |

## Verification
The assertions assume the port fields change only between clock edges. They also assume that when the consumer drops `outReady` while an item is offered, the stall is judged against the registered output and not against the live inputs. The stimulus drives every input on the falling edge and draws `spacingCode` only from its legal 0..7 range. It also leaves `outReady` random in the closing phase, so stalls land both on held items and on idle cycles. Directed cases cover level ties, zero-level pending ports, non-pending high-level ports and misaligned base addresses.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic load;   // output register may take a new result this edge
  } rsvStrobe_t;
endpackage

// File: rtl/rsv_arbiter.sv
module rsv_arbiter #(
  parameter int NUM_PORTS = 32,
  parameter int LVL_W     = 3,
  localparam int IDX_W    = $clog2(NUM_PORTS)
) (
  input  logic [NUM_PORTS-1:0]       pendingVec,
  input  logic [NUM_PORTS*LVL_W-1:0] portLevel,
  output logic                       anyHit,
  output logic [IDX_W-1:0]           winIdx,
  output logic [LVL_W-1:0]           winLevel
);
  logic [LVL_W-1:0] lvl [NUM_PORTS];
  logic [NUM_PORTS-1:0] cand;

  genvar g;
  generate
    for (g = 0; g < NUM_PORTS; g++) begin : g_unpack
      assign lvl[g]  = portLevel[g*LVL_W +: LVL_W];
      assign cand[g] = pendingVec[g] && (portLevel[g*LVL_W +: LVL_W] != '0);
    end
  endgenerate

  // Scan from the top index down; ">=" lets a lower index take a tie.
  always_comb begin
    anyHit   = 1'b0;
    winIdx   = '0;
    winLevel = '0;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (cand[i] && (lvl[i] >= winLevel)) begin
        anyHit   = 1'b1;
        winIdx   = IDX_W'(i);
        winLevel = lvl[i];
      end
    end
  end
endmodule

// File: rtl/rsv_ctrl.sv
module rsv_ctrl
  import rsv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyHit,
  input  logic       outReady,
  output logic       outValid,
  output rsvStrobe_t strobe
);
  logic validQ;

  always_comb begin
    strobe      = '0;
    strobe.load = !validQ || outReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (strobe.load) begin
      validQ <= anyHit;
    end
  end

  assign outValid = validQ;
endmodule

// File: rtl/rsv_datapath.sv
module rsv_datapath
  import rsv_pkg::*;
#(
  parameter int NUM_PORTS = 32,
  parameter int LVL_W     = 3,
  parameter int RSET_W    = 6,
  parameter int ADDR_W    = 32,
  parameter int SPACE_W   = 3,
  localparam int IDX_W    = $clog2(NUM_PORTS),
  localparam int SHIFT_W  = SPACE_W + 1,
  localparam int MIN_SHIFT = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  rsvStrobe_t                  strobe,
  input  logic [IDX_W-1:0]            winIdx,
  input  logic [LVL_W-1:0]            winLevel,
  input  logic [NUM_PORTS*RSET_W-1:0] portRegSet,
  input  logic [NUM_PORTS-1:0]        portNmi,
  input  logic [ADDR_W-1:0]           vecBase,
  input  logic [SPACE_W-1:0]          spacingCode,
  output logic [ADDR_W-1:0]           outAddr,
  output logic [LVL_W-1:0]            outLevel,
  output logic [RSET_W-1:0]           outRegSet,
  output logic                        outNmi
);
  logic [SHIFT_W-1:0] shiftAmt;
  logic [ADDR_W-1:0]  alignMask;
  logic [ADDR_W-1:0]  offset;
  logic [ADDR_W-1:0]  addrNext;
  logic [RSET_W-1:0]  regSetNext;
  logic               nmiNext;

  // Spacing is a power of two, so index*spacing is a left shift
  assign shiftAmt   = {1'b0, spacingCode} + SHIFT_W'(MIN_SHIFT);
  assign alignMask  = ~((ADDR_W'(1) << shiftAmt) - ADDR_W'(1));
  assign offset     = ADDR_W'(winIdx) << shiftAmt;
  assign addrNext   = (vecBase & alignMask) + offset;
  assign regSetNext = portRegSet[winIdx*RSET_W +: RSET_W];
  assign nmiNext    = portNmi[winIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outAddr   <= '0;
      outLevel  <= '0;
      outRegSet <= '0;
      outNmi    <= 1'b0;
    end else if (strobe.load) begin
      outAddr   <= addrNext;
      outLevel  <= winLevel;
      outRegSet <= regSetNext;
      outNmi    <= nmiNext;
    end
  end
endmodule

// File: rtl/vec_prio_resolver.sv
module vec_prio_resolver
  import rsv_pkg::*;
#(
  parameter int NUM_PORTS = 32,
  parameter int LVL_W     = 3,
  parameter int RSET_W    = 6,
  parameter int ADDR_W    = 32,
  parameter int SPACE_W   = 3,
  localparam int IDX_W    = $clog2(NUM_PORTS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PORTS-1:0]        pendingVec,
  input  logic [NUM_PORTS*LVL_W-1:0]  portLevel,
  input  logic [NUM_PORTS*RSET_W-1:0] portRegSet,
  input  logic [NUM_PORTS-1:0]        portNmi,
  input  logic [ADDR_W-1:0]           vecBase,
  input  logic [SPACE_W-1:0]          spacingCode,
  output logic                        outValid,
  input  logic                        outReady,
  output logic [ADDR_W-1:0]           outAddr,
  output logic [LVL_W-1:0]            outLevel,
  output logic [RSET_W-1:0]           outRegSet,
  output logic                        outNmi
);
  logic             anyHit;
  logic [IDX_W-1:0] winIdx;
  logic [LVL_W-1:0] winLevel;
  rsvStrobe_t       strobe;

  rsv_arbiter #(.NUM_PORTS(NUM_PORTS), .LVL_W(LVL_W)) u_arb (
    .pendingVec (pendingVec),
    .portLevel  (portLevel),
    .anyHit     (anyHit),
    .winIdx     (winIdx),
    .winLevel   (winLevel)
  );

  rsv_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .anyHit   (anyHit),
    .outReady (outReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  rsv_datapath #(
    .NUM_PORTS (NUM_PORTS),
    .LVL_W     (LVL_W),
    .RSET_W    (RSET_W),
    .ADDR_W    (ADDR_W),
    .SPACE_W   (SPACE_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .winIdx      (winIdx),
    .winLevel    (winLevel),
    .portRegSet  (portRegSet),
    .portNmi     (portNmi),
    .vecBase     (vecBase),
    .spacingCode (spacingCode),
    .outAddr     (outAddr),
    .outLevel    (outLevel),
    .outRegSet   (outRegSet),
    .outNmi      (outNmi)
  );
endmodule

// File: rtl/rsv_checker.sv
module rsv_checker #(
  parameter int NUM_PORTS = 32,
  parameter int LVL_W     = 3,
  parameter int RSET_W    = 6,
  parameter int ADDR_W    = 32
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [NUM_PORTS-1:0]       pendingVec,
  input logic [NUM_PORTS*LVL_W-1:0] portLevel,
  input logic                       outValid,
  input logic                       outReady,
  input logic [ADDR_W-1:0]          outAddr,
  input logic [LVL_W-1:0]           outLevel,
  input logic [RSET_W-1:0]          outRegSet,
  input logic                       outNmi
);
  logic             anyCand;
  logic [LVL_W-1:0] maxLvl;
  logic             canLoad;

  always_comb begin
    anyCand = 1'b0;
    maxLvl  = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (pendingVec[i]) begin
        if (portLevel[i*LVL_W +: LVL_W] != '0) anyCand = 1'b1;
        if (portLevel[i*LVL_W +: LVL_W] > maxLvl) maxLvl = portLevel[i*LVL_W +: LVL_W];
      end
    end
  end

  assign canLoad = !outValid || outReady;

  // R10
  hold_payload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outAddr) && $stable(outLevel)
                                 && $stable(outRegSet) && $stable(outNmi)));

  // R4
  level_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outLevel != '0));

  // R9
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (canLoad && anyCand) |=> outValid);

  // R9
  valid_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (canLoad && !anyCand) |=> !outValid);

  // R2
  max_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (canLoad && anyCand) |=> (outLevel == $past(maxLvl)));
endmodule

bind vec_prio_resolver rsv_checker #(
  .NUM_PORTS (NUM_PORTS),
  .LVL_W     (LVL_W),
  .RSET_W    (RSET_W),
  .ADDR_W    (ADDR_W)
) u_rsv_chk (
  .clk        (clk),
  .rstN       (rstN),
  .pendingVec (pendingVec),
  .portLevel  (portLevel),
  .outValid   (outValid),
  .outReady   (outReady),
  .outAddr    (outAddr),
  .outLevel   (outLevel),
  .outRegSet  (outRegSet),
  .outNmi     (outNmi)
);

// File: tb/tb_vec_prio_resolver.sv
`timescale 1ns/1ps
module tb_vec_prio_resolver;
  localparam int NP = 32;
  localparam int LW = 3;
  localparam int RW = 6;
  localparam int AW = 32;
  localparam int SW = 3;

  typedef struct {
    logic          valid;
    logic [AW-1:0] addr;
    logic [LW-1:0] level;
    logic [RW-1:0] rset;
    logic          nmi;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0]    pendingVec = '0;
  logic [NP*LW-1:0] portLevel = '0;
  logic [NP*RW-1:0] portRegSet = '0;
  logic [NP-1:0]    portNmi = '0;
  logic [AW-1:0]    vecBase = '0;
  logic [SW-1:0]    spacingCode = '0;
  logic             outReady = 1'b1;
  logic             outValid;
  logic [AW-1:0]    outAddr;
  logic [LW-1:0]    outLevel;
  logic [RW-1:0]    outRegSet;
  logic             outNmi;

  logic [LW-1:0] lvlA  [NP];
  logic [RW-1:0] rsetA [NP];

  expItem_t expQ [$];
  string    tagQ [$];
  expItem_t lastExp;
  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vec_prio_resolver dut (
    .clk(clk), .rstN(rstN), .pendingVec(pendingVec), .portLevel(portLevel),
    .portRegSet(portRegSet), .portNmi(portNmi), .vecBase(vecBase),
    .spacingCode(spacingCode), .outValid(outValid), .outReady(outReady),
    .outAddr(outAddr), .outLevel(outLevel), .outRegSet(outRegSet), .outNmi(outNmi)
  );

  task automatic clearPorts();
    pendingVec = '0;
    portNmi    = '0;
    for (int i = 0; i < NP; i++) begin
      lvlA[i]  = '0;
      rsetA[i] = RW'(i + 1);
    end
  endtask

  task automatic setPort(int idx, bit pend, int lvl, bit nmi);
    pendingVec[idx] = pend;
    lvlA[idx]       = LW'(lvl);
    portNmi[idx]    = nmi;
  endtask

  // Reference: upward scan, strict greater keeps the lowest index on ties
  function automatic expItem_t model();
    expItem_t e;
    int best = -1;
    logic [LW-1:0] bestL = '0;
    logic [AW-1:0] bytes;
    for (int i = 0; i < NP; i++) begin
      if (pendingVec[i] && lvlA[i] != 0 && lvlA[i] > bestL) begin
        best  = i;
        bestL = lvlA[i];
      end
    end
    bytes   = AW'(4) << spacingCode;
    e.valid = (best >= 0);
    e.level = bestL;
    e.rset  = (best >= 0) ? rsetA[best] : '0;
    e.nmi   = (best >= 0) ? portNmi[best] : 1'b0;
    e.addr  = (vecBase & ~(bytes - 1)) + ((best >= 0) ? AW'(best) * bytes : '0);
    return e;
  endfunction

  // Driver: called just after a falling edge; drives, predicts, waits one cycle
  task automatic apply(string tag);
    expItem_t e;
    for (int i = 0; i < NP; i++) begin
      portLevel[i*LW +: LW]  = lvlA[i];
      portRegSet[i*RW +: RW] = rsetA[i];
    end
    if (lastExp.valid && !outReady) e = lastExp;   // R10 hold
    else e = model();
    lastExp = e;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  // Monitor: one edge after the driver, output is settled
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        string t;
        bit bad;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        testCount++;
        bad = (outValid !== e.valid);
        if (e.valid && !bad)
          bad = (outAddr !== e.addr) || (outLevel !== e.level) ||
                (outRegSet !== e.rset) || (outNmi !== e.nmi);
        if (bad) begin
          failCount++;
          $display("FAIL %s: got v=%0b a=%h l=%0d r=%0d n=%0b exp v=%0b a=%h l=%0d r=%0d n=%0b",
                   t, outValid, outAddr, outLevel, outRegSet, outNmi,
                   e.valid, e.addr, e.level, e.rset, e.nmi);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    lastExp = '{valid: 1'b0, addr: '0, level: '0, rset: '0, nmi: 1'b0};
    clearPorts();
    setPort(3, 1, 5, 1);
    for (int i = 0; i < NP; i++) portLevel[i*LW +: LW] = lvlA[i];
    repeat (3) @(negedge clk);
    // R1: reset holds outputs at zero even with a candidate present
    testCount++;
    if (outValid !== 1'b0 || outAddr !== '0 || outLevel !== '0 || outRegSet !== '0 || outNmi !== 1'b0) begin
      failCount++;
      $display("FAIL R1: got v=%0b a=%h l=%0d exp all zero", outValid, outAddr, outLevel);
    end
    rstN = 1'b1;
    @(negedge clk);
    clearPorts();
    apply("R9_idle");

    // R6 R8 R11: single port, 4-byte spacing
    vecBase = 32'h0000_1000; spacingCode = 3'd0;
    setPort(5, 1, 3, 1);
    apply("R6_single");

    // R2: largest level wins
    clearPorts();
    setPort(2, 1, 1, 0); setPort(9, 1, 6, 1); setPort(30, 1, 4, 0);
    spacingCode = 3'd2;
    apply("R2_largest");

    // R3: tie goes to lowest index
    clearPorts();
    setPort(7, 1, 5, 0); setPort(3, 1, 5, 1); setPort(20, 1, 5, 0);
    apply("R3_tie");

    // R4: zero level pending port loses; 512-byte spacing
    clearPorts();
    setPort(0, 1, 0, 1); setPort(31, 1, 1, 0);
    vecBase = 32'hA000_0000; spacingCode = 3'd7;
    apply("R4_zero_level");

    // R4 R9: only zero-level ports pending -> nothing offered
    clearPorts();
    setPort(1, 1, 0, 0); setPort(15, 1, 0, 1);
    apply("R4_all_zero");

    // R5: non-pending high level never wins
    clearPorts();
    setPort(4, 0, 7, 1); setPort(10, 1, 2, 0);
    apply("R5_not_pending");

    // R7: misaligned base bits dropped, 32-byte spacing
    clearPorts();
    setPort(6, 1, 3, 1);
    vecBase = 32'h0001_2345; spacingCode = 3'd3;
    apply("R7_base_align");
    spacingCode = 3'd1; vecBase = 32'hFFFF_FFFF;
    apply("R7_base_align2");

    // R10: stall holds while inputs change
    outReady = 1'b0;
    clearPorts();
    setPort(12, 1, 7, 0);
    apply("R10_stall1");
    setPort(13, 1, 7, 1);
    apply("R10_stall2");
    outReady = 1'b1;
    apply("R11_release");

    // R9: nothing pending
    clearPorts();
    apply("R9_empty");

    // Random phase: R2 R3 R6 R8 R10
    for (int n = 0; n < 60; n++) begin
      clearPorts();
      for (int i = 0; i < NP; i++) begin
        if ($urandom_range(0, 3) == 0) begin
          setPort(i, 1, $urandom_range(0, 7), 1'($urandom_range(0, 1)));
          rsetA[i] = RW'($urandom_range(0, 63));
        end
      end
      vecBase     = $urandom;
      spacingCode = SW'($urandom_range(0, 7));
      outReady    = ($urandom_range(0, 3) != 0);
      apply("R2_R10_random");
    end
    outReady = 1'b1;
    apply("R11_final");
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule